// File: doc/BRIEF.md
# Sixteen-bit arithmetic and logic unit with status flags

This block is the execute stage arithmetic of a small processor. Each cycle it takes a destination operand, a second operand chosen between a latched register value and an immediate, a five-bit operation code and a four-bit shift amount. It returns the result for write-back, a write-enable for the destination register, and a status flag register that it owns. The flag register holds carry (bit 0), zero (bit 1), negative (bit 2) and signed overflow (bit 3).

The result and write-enable are combinational from the inputs and the stored flags. The flags are registered and update on the clock edge when `valid_i` is high. Carry-dependent operations read the stored carry. Compare and test only update the flags. The two mask operations clear or set flag bits directly, using the low four bits of the selected operand as the mask. The register file and the instruction sequencing are outside this block.

Top module: `alu16`

## Requirements
- R1: Operation codes are ADD=0, ADC=1, SUB=2, SBC=3, AND=4, OR=5, XOR=6, NOT=7, NEG=8, INC=9, DEC=10, CMP=11, TST=12, ASR=13, ASL=14, ROR=15, ROL=16, FCLR=17 and FSET=18. ADD returns dst+opnd and ADC returns dst+opnd+C, both modulo 2^16. C takes the unsigned carry out and V takes the signed overflow.
- R2: SUB returns dst-opnd and SBC returns dst-opnd-C. C is set when the unsigned subtraction borrows, and V is set on signed overflow.
- R3: CMP sets flags as SUB does and TST sets flags as dst-0 (C=0, V=0), and neither raises the write-enable.
- R4: NOT returns ~dst and NEG returns 0-dst (C set when dst is non-zero, V set when dst is 0x8000). INC returns dst+1 (carry out into C). DEC returns dst-1 (C set when dst is 0). All four write the destination.
- R5: AND, OR and XOR combine dst with opnd. All logic operations, NOT included, clear C and V.
- R6: For every operation that computes a result (ADD to ROL), the next Z is 1 exactly when the 16-bit result is zero and the next N equals result bit 15.
- R7: ASR shifts dst right by the shift amount and fills from bit 15. ASL shifts left and fills with zeros. C takes the last bit shifted out and V is cleared.
- R8: ROR rotates dst right by the shift amount and C takes the new bit 15. ROL rotates left and C takes the new bit 0. V is cleared.
- R9: A shift or rotate with a shift amount of zero returns dst unchanged and leaves C unchanged.
- R10: FCLR sets flags to flags AND NOT mask and FSET sets flags to flags OR mask, with mask = opnd[3:0]. Neither raises the write-enable.
- R11: With imm_sel_i high the second operand is imm_i, and with it low the second operand is opnd_i.
- R12: With valid_i low the write-enable is low and the flags hold. Codes 19 to 31 never write and leave the flags unchanged.
- R13: An active-low reset clears all four flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | An operation is presented this cycle |
| op_i | input | 5 | Operation code |
| dst_i | input | 16 | Destination register operand |
| opnd_i | input | 16 | Latched second operand |
| imm_i | input | 16 | Immediate second operand |
| imm_sel_i | input | 1 | Selects the immediate as second operand |
| shamt_i | input | 4 | Shift or rotate amount |
| result_o | output | 16 | Result for write-back |
| wr_en_o | output | 1 | Write the result to the destination |
| flags_o | output | 4 | Stored flags {V,N,Z,C} |

## Verification
The carry- and borrow-dependent results are the hardest to reach. They depend on the stored carry, which the ports can only set through earlier operations. Before each vector the bench therefore runs a flag clear with a full mask and then a flag set with a chosen pattern, which puts either carry state in place. The operand set holds 0, 1, 0x7FFF, 0x8000, 0x8001 and 0xFFFF, so carries, borrows and signed overflow occur at the word edges. The sweep also covers shift amounts 0, 1, 7 and 15, all 32 operation codes, and both operand sources.

// File: rtl/alu16_pkg.sv
package alu16_pkg;
  localparam int unsigned FLAG_W = 4;
  localparam int unsigned FC = 0;
  localparam int unsigned FZ = 1;
  localparam int unsigned FN = 2;
  localparam int unsigned FV = 3;

  typedef enum logic [4:0] {
    OP_ADD  = 5'd0,  OP_ADC  = 5'd1,  OP_SUB = 5'd2,  OP_SBC = 5'd3,
    OP_AND  = 5'd4,  OP_OR   = 5'd5,  OP_XOR = 5'd6,  OP_NOT = 5'd7,
    OP_NEG  = 5'd8,  OP_INC  = 5'd9,  OP_DEC = 5'd10, OP_CMP = 5'd11,
    OP_TST  = 5'd12, OP_ASR  = 5'd13, OP_ASL = 5'd14, OP_ROR = 5'd15,
    OP_ROL  = 5'd16, OP_FCLR = 5'd17, OP_FSET = 5'd18
  } alu_op_e;

  typedef enum logic [2:0] {
    CL_ARITH, CL_LOGIC, CL_SHIFT, CL_FLAG, CL_NONE
  } op_class_e;

  function automatic op_class_e classify(input logic [4:0] op);
    case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_NEG,
      OP_INC, OP_DEC, OP_CMP, OP_TST:         return CL_ARITH;
      OP_AND, OP_OR, OP_XOR, OP_NOT:          return CL_LOGIC;
      OP_ASR, OP_ASL, OP_ROR, OP_ROL:         return CL_SHIFT;
      OP_FCLR, OP_FSET:                       return CL_FLAG;
      default:                                return CL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/alu16_arith.sv
module alu16_arith
  import alu16_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic [4:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] res,
  output logic         c_out,
  output logic         v_out
);
  // One adder serves every arithmetic form; subtraction adds the inverse.
  function automatic logic [W:0] add_full(input logic [W-1:0] l,
                                          input logic [W-1:0] r,
                                          input logic ci);
    return {1'b0, l} + {1'b0, r} + {{W{1'b0}}, ci};
  endfunction

  function automatic logic ovf(input logic [W-1:0] l, input logic [W-1:0] r,
                               input logic [W-1:0] s);
    return (l[W-1] == r[W-1]) && (s[W-1] != l[W-1]);
  endfunction

  logic [W-1:0] lhs, rhs;
  logic         ci, borrow_mode;
  logic [W:0]   sum;

  always_comb begin
    lhs = a;
    rhs = b;
    ci = 1'b0;
    borrow_mode = 1'b0;
    case (op)
      OP_ADC: ci = cin;
      OP_SUB, OP_CMP: begin rhs = ~b; ci = 1'b1; borrow_mode = 1'b1; end
      OP_SBC: begin rhs = ~b; ci = ~cin; borrow_mode = 1'b1; end
      OP_TST: begin rhs = '1; ci = 1'b1; borrow_mode = 1'b1; end
      OP_NEG: begin lhs = '0; rhs = ~a; ci = 1'b1; borrow_mode = 1'b1; end
      OP_INC: begin rhs = '0; ci = 1'b1; end
      OP_DEC: begin rhs = '1; borrow_mode = 1'b1; end
      default: ;
    endcase
  end

  assign sum   = add_full(lhs, rhs, ci);
  assign res   = sum[W-1:0];
  assign c_out = borrow_mode ? ~sum[W] : sum[W];
  assign v_out = ovf(lhs, rhs, sum[W-1:0]);
endmodule

// File: rtl/alu16_logic.sv
module alu16_logic
  import alu16_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic [4:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] res
);
  always_comb begin
    case (op)
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_XOR:  res = a ^ b;
      OP_NOT:  res = ~a;
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/alu16_shift.sv
module alu16_shift
  import alu16_pkg::*;
#(
  parameter int unsigned W   = 16,
  parameter int unsigned SHW = $clog2(W)
) (
  input  logic [4:0]     op,
  input  logic [W-1:0]   a,
  input  logic [SHW-1:0] shamt,
  input  logic           cin,
  output logic [W-1:0]   res,
  output logic           c_out
);
  localparam int unsigned DW = 2 * W;

  // Each form returns {carry, result}; the carry is the last bit moved out.
  function automatic logic [W:0] f_asr(input logic [W-1:0] x, input logic [SHW-1:0] s);
    logic signed [W:0] ext;
    ext = $signed({x, 1'b0}) >>> s;
    return {ext[0], ext[W:1]};
  endfunction

  function automatic logic [W:0] f_asl(input logic [W-1:0] x, input logic [SHW-1:0] s);
    logic [W:0] ext;
    ext = {1'b0, x} << s;
    return ext;
  endfunction

  function automatic logic [W:0] f_ror(input logic [W-1:0] x, input logic [SHW-1:0] s);
    logic [DW-1:0] dbl;
    dbl = {x, x} >> s;
    return {dbl[W-1], dbl[W-1:0]};
  endfunction

  function automatic logic [W:0] f_rol(input logic [W-1:0] x, input logic [SHW-1:0] s);
    logic [DW-1:0] dbl;
    dbl = {x, x} << s;
    return {dbl[W], dbl[DW-1:W]};
  endfunction

  logic [W:0] pick;

  always_comb begin
    case (op)
      OP_ASR:  pick = f_asr(a, shamt);
      OP_ASL:  pick = f_asl(a, shamt);
      OP_ROR:  pick = f_ror(a, shamt);
      OP_ROL:  pick = f_rol(a, shamt);
      default: pick = {1'b0, a};
    endcase
  end

  assign res   = pick[W-1:0];
  assign c_out = (shamt == '0) ? cin : pick[W];
endmodule

// File: rtl/alu16.sv
module alu16
  import alu16_pkg::*;
#(
  parameter int unsigned W   = 16,
  parameter int unsigned SHW = $clog2(W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_i,
  input  logic [4:0]        op_i,
  input  logic [W-1:0]      dst_i,
  input  logic [W-1:0]      opnd_i,
  input  logic [W-1:0]      imm_i,
  input  logic              imm_sel_i,
  input  logic [SHW-1:0]    shamt_i,
  output logic [W-1:0]      result_o,
  output logic              wr_en_o,
  output logic [FLAG_W-1:0] flags_o
);
  logic [W-1:0]      opnd_sel;
  logic [FLAG_W-1:0] flags_q, flags_d;
  logic [W-1:0]      ar_res, lg_res, sh_res;
  logic              ar_c, ar_v, sh_c;
  logic              wr_raw;
  op_class_e         cls;

  // Named events for the checker.
  logic is_arith, is_logic, is_shift, is_flag, no_write_op, shamt_zero;

  assign opnd_sel    = imm_sel_i ? imm_i : opnd_i;
  assign cls         = classify(op_i);
  assign is_arith    = (cls == CL_ARITH);
  assign is_logic    = (cls == CL_LOGIC);
  assign is_shift    = (cls == CL_SHIFT);
  assign is_flag     = (cls == CL_FLAG);
  assign no_write_op = (cls == CL_NONE) || is_flag ||
                       (op_i == OP_CMP) || (op_i == OP_TST);
  assign shamt_zero  = (shamt_i == '0);

  alu16_arith #(.W(W)) u_arith (
    .op(op_i), .a(dst_i), .b(opnd_sel), .cin(flags_q[FC]),
    .res(ar_res), .c_out(ar_c), .v_out(ar_v)
  );

  alu16_logic #(.W(W)) u_logic (
    .op(op_i), .a(dst_i), .b(opnd_sel), .res(lg_res)
  );

  alu16_shift #(.W(W), .SHW(SHW)) u_shift (
    .op(op_i), .a(dst_i), .shamt(shamt_i), .cin(flags_q[FC]),
    .res(sh_res), .c_out(sh_c)
  );

  always_comb begin
    result_o = '0;
    flags_d  = flags_q;
    case (cls)
      CL_ARITH: begin
        result_o = ar_res;
        flags_d  = {ar_v, ar_res[W-1], ar_res == '0, ar_c};
      end
      CL_LOGIC: begin
        result_o = lg_res;
        flags_d  = {1'b0, lg_res[W-1], lg_res == '0, 1'b0};
      end
      CL_SHIFT: begin
        result_o = sh_res;
        flags_d  = {1'b0, sh_res[W-1], sh_res == '0, sh_c};
      end
      CL_FLAG: begin
        if (op_i == OP_FCLR) flags_d = flags_q & ~opnd_sel[FLAG_W-1:0];
        else                 flags_d = flags_q | opnd_sel[FLAG_W-1:0];
      end
      default: ;
    endcase
  end

  assign wr_raw  = !no_write_op;
  assign wr_en_o = valid_i && wr_raw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flags_q <= '0;
    else if (valid_i) flags_q <= flags_d;
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/alu16_chk.sv
module alu16_chk
  import alu16_pkg::*;
#(
  parameter int unsigned W   = 16,
  parameter int unsigned SHW = $clog2(W)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              valid_i,
  input logic [4:0]        op_i,
  input logic [W-1:0]      dst_i,
  input logic [W-1:0]      opnd_sel,
  input logic [W-1:0]      result_o,
  input logic              wr_en_o,
  input logic [FLAG_W-1:0] flags_o,
  input logic              is_logic,
  input logic              is_shift,
  input logic              no_write_op,
  input logic              shamt_zero
);
  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |-> !wr_en_o); // R12

  AST_IDLE_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> $stable(flags_o)); // R12

  AST_CMP_TST_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_CMP || op_i == OP_TST) |-> !wr_en_o); // R3

  AST_MASK_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_FCLR || op_i == OP_FSET) |-> !wr_en_o); // R10

  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && wr_en_o) |=> (flags_o[FZ] == ($past(result_o) == '0))); // R6

  AST_NEG_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && wr_en_o) |=> (flags_o[FN] == $past(result_o[W-1]))); // R6

  AST_LOGIC_CLEARS_CV: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && is_logic) |=> (!flags_o[FC] && !flags_o[FV])); // R5

  AST_SHIFT_ZERO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && is_shift && shamt_zero) |-> (result_o == dst_i)); // R9

  AST_SHIFT_ZERO_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && is_shift && shamt_zero) |=> (flags_o[FC] == $past(flags_o[FC]))); // R9

  AST_FSET_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i == OP_FSET) |=>
      ((flags_o & $past(opnd_sel[FLAG_W-1:0])) == $past(opnd_sel[FLAG_W-1:0]))); // R10

  AST_FCLR_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i == OP_FCLR) |=>
      ((flags_o & $past(opnd_sel[FLAG_W-1:0])) == '0)); // R10

  AST_UNDEF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && no_write_op && op_i > OP_FSET) |=> $stable(flags_o)); // R12
endmodule

bind alu16 alu16_chk #(.W(W), .SHW(SHW)) u_chk (
  .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_i(op_i), .dst_i(dst_i),
  .opnd_sel(opnd_sel), .result_o(result_o), .wr_en_o(wr_en_o),
  .flags_o(flags_o), .is_logic(is_logic), .is_shift(is_shift),
  .no_write_op(no_write_op), .shamt_zero(shamt_zero)
);

// File: tb/alu16_bench.sv
module alu16_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [4:0]  op_i = '0;
  logic [15:0] dst_i = '0, opnd_i = '0, imm_i = '0;
  logic        imm_sel_i = 1'b0;
  logic [3:0]  shamt_i = '0;
  logic [15:0] result_o;
  logic        wr_en_o;
  logic [3:0]  flags_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  alu16 u_alu16 (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_i(op_i), .dst_i(dst_i),
    .opnd_i(opnd_i), .imm_i(imm_i), .imm_sel_i(imm_sel_i), .shamt_i(shamt_i),
    .result_o(result_o), .wr_en_o(wr_en_o), .flags_o(flags_o)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp, input logic [4:0] op);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s op=%0d actual=%h expected=%h", req, op, act, exp);
    end
  endtask

  function automatic int sv(input logic [15:0] x);
    return x[15] ? int'(x) - 65536 : int'(x);
  endfunction

  // Reference model written from the requirements.
  task automatic model(input logic [4:0] op, input logic [15:0] a, input logic [15:0] b,
                       input logic [3:0] s, input logic [3:0] fl,
                       output logic wr, output logic [15:0] r, output logic [3:0] nf);
    int d, sd;
    logic c, v, upd;
    c = fl[0]; v = 1'b0; wr = 1'b1; upd = 1'b1; r = '0; nf = fl;
    d = 0; sd = 0;
    case (op)
      0, 1: begin                                       // R1
        d  = int'(a) + int'(b) + ((op == 1) ? int'(fl[0]) : 0);
        sd = sv(a) + sv(b) + ((op == 1) ? int'(fl[0]) : 0);
        c = d > 65535; r = d[15:0];
        v = (sd > 32767) || (sd < -32768);
      end
      2, 3, 11, 12, 8, 10: begin                        // R2 R3 R4
        int x, sx, bi;
        x = int'(b); sx = sv(b); bi = 0;
        if (op == 3) bi = int'(fl[0]);
        if (op == 12) begin x = 0; sx = 0; end
        if (op == 10) begin x = 1; sx = 1; end
        if (op == 8) begin
          d = 0 - int'(a); sd = 0 - sv(a);
        end else begin
          d = int'(a) - x - bi; sd = sv(a) - sx - bi;
        end
        c = d < 0; r = d[15:0];
        v = (sd > 32767) || (sd < -32768);
        if (op == 11 || op == 12) wr = 1'b0;
      end
      9: begin                                          // R4
        d = int'(a) + 1; sd = sv(a) + 1;
        c = d > 65535; r = d[15:0];
        v = sd > 32767;
      end
      4: begin r = a & b; c = 0; end                    // R5
      5: begin r = a | b; c = 0; end
      6: begin r = a ^ b; c = 0; end
      7: begin r = ~a;    c = 0; end
      13, 14, 15, 16: begin                             // R7 R8 R9
        r = a;
        for (int i = 0; i < int'(s); i++) begin
          case (op)
            13: begin c = r[0];  r = {r[15], r[15:1]}; end
            14: begin c = r[15]; r = {r[14:0], 1'b0}; end
            15: begin r = {r[0], r[15:1]}; c = r[15]; end
            default: begin r = {r[14:0], r[15]}; c = r[0]; end
          endcase
        end
      end
      17: begin wr = 0; upd = 0; nf = fl & ~b[3:0]; end // R10
      18: begin wr = 0; upd = 0; nf = fl | b[3:0]; end
      default: begin wr = 0; upd = 0; end               // R12
    endcase
    if (upd) nf = {v, r[15], r == 16'h0000, c};         // R6
  endtask

  logic [15:0] vals [10];

  initial begin
    vals[0] = 16'h0000; vals[1] = 16'h0001; vals[2] = 16'h7FFF; vals[3] = 16'h8000;
    vals[4] = 16'hFFFF; vals[5] = 16'h8001; vals[6] = 16'h00FF; vals[7] = 16'h5555;
    vals[8] = 16'hAAAA; vals[9] = 16'h1234;

    repeat (3) @(negedge clk);
    check(flags_o == 4'h0, "R13 reset flags", 32'(flags_o), 0, 0);
    check(wr_en_o == 1'b0, "R12 idle no write", 32'(wr_en_o), 0, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int op = 0; op < 32; op++)
      for (int ia = 0; ia < 10; ia++)
        for (int ib = 0; ib < 10; ib++)
          for (int k = 0; k < 2; k++)
            for (int si = 0; si < 4; si++) begin
              logic [3:0]  pre, nf, s;
              logic [15:0] a, b, r;
              logic        wr, sel;
              a = vals[ia]; b = vals[ib];
              pre = k ? 4'b1011 : 4'b0100;
              s = (si == 0) ? 4'd0 : (si == 1) ? 4'd1 : (si == 2) ? 4'd7 : 4'd15;
              sel = ((ia + ib + si) % 2) == 1;
              // preload flags: clear all, then set pattern
              valid_i = 1'b1; op_i = 5'd17; imm_sel_i = 1'b1; imm_i = 16'h000F;
              @(negedge clk);
              op_i = 5'd18; imm_i = {12'h000, pre};
              @(negedge clk);
              // present the vector idle first (R12)
              valid_i = 1'b0; op_i = 5'(op); dst_i = a; shamt_i = s;
              imm_sel_i = sel;
              imm_i  = sel ? b : ~b;    // R11 the unselected source carries junk
              opnd_i = sel ? ~b : b;
              #1;
              check(wr_en_o == 1'b0, "R12 idle no write", 32'(wr_en_o), 0, 5'(op));
              check(flags_o == pre, "R10 flag preload", 32'(flags_o), 32'(pre), 5'(op));
              @(negedge clk);
              check(flags_o == pre, "R12 idle flags hold", 32'(flags_o), 32'(pre), 5'(op));
              valid_i = 1'b1;
              #1;
              model(5'(op), a, b, s, pre, wr, r, nf);
              check(wr_en_o == wr, "R3 R10 R12 write enable", 32'(wr_en_o), 32'(wr), 5'(op));
              if (wr)
                check(result_o == r, "R1 R2 R4 R5 R7 R8 R9 R11 result",
                      32'(result_o), 32'(r), 5'(op));
              @(negedge clk);
              check(flags_o == nf, "R1 R2 R3 R6 R7 R8 R9 R10 flags",
                    32'(flags_o), 32'(nf), 5'(op));
            end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule